// File: doc/BRIEF.md
# Two-Channel DMA Control and Status Register

This block is the control and status register for a two-channel DMA controller. A CPU writes it through an 8-bit strobe-and-data port and reads it back through a combinational read-data port. Each channel has an enable bit and an interrupt-enable bit. Each channel also has a write qualifier. A write changes a channel's enable bit only when that channel's qualifier bit is 0 in the same data byte, so software can update one channel without disturbing the other. A single main-enable bit gates both channels. Software cannot write the main-enable bit directly. A qualified write of 1 to either channel enable sets it, and a non-maskable-interrupt event clears it.

The DMA engine drives a per-channel termination pulse when that channel's byte count reaches zero. The pulse clears the channel's enable bit. The block outputs a per-channel active signal and a per-channel interrupt request. An interrupt request is raised while a channel is idle and its interrupt is enabled.

The main enable is held by a two-state machine:
- `MAIN_OFF` is the reset state. The transition `ARM` leads from `MAIN_OFF` to `MAIN_ON` on a qualified write of 1 to any channel enable with no NMI in that cycle.
- In `MAIN_ON`, a qualified write of 1 without NMI takes the transition `REARM` and stays in `MAIN_ON`.
- The transition `HALT` leads from `MAIN_ON` to `MAIN_OFF` on an NMI event.
- In all other cases the state holds.

Top module: `dma_ctl_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x32, and both `chan_active` and `irq_req` are 0.
- R2: On a write, the enable bit of channel 1 (data bit 7) updates only when data bit 5 is 0. The enable bit of channel 0 (data bit 6) updates only when data bit 4 is 0.
- R3: On a write whose qualifier bit for a channel is 1, or with no write, that channel's enable bit keeps its value.
- R4: The read layout is: bit 7 is the channel-1 enable, bit 6 the channel-0 enable, bit 3 the channel-1 interrupt enable, bit 2 the channel-0 interrupt enable, and bit 0 the main enable. Bits 5, 4 and 1 always read 1.
- R5: Write data bit 0 has no effect on the main enable.
- R6: A qualified write of 1 to either channel enable sets the main enable, even if that enable bit was already 1.
- R7: An NMI event clears the main enable in the next cycle and leaves both channel enable bits unchanged.
- R8: `chan_active[i]` is 1 exactly when channel i's enable bit and the main enable are both 1.
- R9: A termination pulse clears that channel's enable bit. It wins over a qualified write of 1 in the same cycle.
- R10: `irq_req[i]` is 1 exactly when channel i's enable bit is 0 and its interrupt-enable bit is 1.
- R11: The interrupt-enable bits take write data bits 3 and 2 on every write, with no qualifier.
- R12: An NMI event in the same cycle as a qualified write of 1 leaves the main enable at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Register read value |
| term_pulse | input | 2 | Per-channel termination pulse (byte count reached zero) |
| nmi_evt | input | 1 | Non-maskable-interrupt event, one cycle |
| chan_active | output | 2 | Per-channel transfer permission |
| irq_req | output | 2 | Per-channel termination interrupt request |

## Verification
The assertions expect `wr_en`, `term_pulse` and `nmi_evt` to be sampled as one-cycle events on the rising edge. They also expect these inputs never to be X or Z after reset. The bench drives each input at the falling edge, so every input is stable across the sampling edge. The bench sweeps every write byte against every combination of termination pulses and NMI, with the strobe both high and low, and carries the register state from vector to vector. This covers the coincident cases where termination and NMI compete with a qualified write.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    localparam int NUM_CH    = 2;
    localparam int DATA_W    = 8;
    localparam int EN_BASE   = 6;
    localparam int QUAL_BASE = 4;
    localparam int IE_BASE   = 2;
    localparam int SPARE_BIT = 1;
    localparam int MAIN_BIT  = 0;

    typedef enum logic {
        MAIN_OFF = 1'b0,
        MAIN_ON  = 1'b1
    } main_state_t;
endpackage

// File: rtl/dsr_chan.sv
module dsr_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic d_en,
    input  logic d_qual,
    input  logic d_ie,
    input  logic term,
    output logic en,
    output logic ie,
    output logic set_req
);
    logic qual_wr;

    assign qual_wr = wr_en && !d_qual;
    assign set_req = qual_wr && d_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
            ie <= 1'b0;
        end else begin
            if (term)         en <= 1'b0;
            else if (qual_wr) en <= d_en;
            if (wr_en)        ie <= d_ie;
        end
    end

    // R9
    term_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> !en);

    // R3
    unqual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!term && !(wr_en && !d_qual)) |=> $stable(en));

    // R11
    ie_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ie == $past(d_ie)));
endmodule

// File: rtl/dsr_main_fsm.sv
module dsr_main_fsm
    import dsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_any,
    input  logic nmi,
    output logic main_on
);
    main_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= MAIN_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MAIN_OFF: if (set_any && !nmi) state_nx = MAIN_ON;   // ARM
            MAIN_ON:  if (nmi)             state_nx = MAIN_OFF;  // HALT
                                                                  // REARM: stay
            default:                       state_nx = MAIN_OFF;
        endcase
    end

    always_comb main_on = (state == MAIN_ON);

    // R7
    nmi_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> (state == MAIN_OFF));

    // R6
    set_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_any && !nmi) |=> (state == MAIN_ON));

    // R5
    main_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_any && !nmi) |=> $stable(state));
endmodule

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
    import dsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_CH-1:0] term_pulse,
    input  logic              nmi_evt,
    output logic [NUM_CH-1:0] chan_active,
    output logic [NUM_CH-1:0] irq_req
);
    logic [NUM_CH-1:0] en, ie, set_req;
    logic              main_on;
    logic              unused_bits;

    assign unused_bits = ^wr_data[SPARE_BIT:MAIN_BIT];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dsr_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .d_en    (wr_data[EN_BASE+i]),
            .d_qual  (wr_data[QUAL_BASE+i]),
            .d_ie    (wr_data[IE_BASE+i]),
            .term    (term_pulse[i]),
            .en      (en[i]),
            .ie      (ie[i]),
            .set_req (set_req[i])
        );
    end

    dsr_main_fsm u_main (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_any (|set_req),
        .nmi     (nmi_evt),
        .main_on (main_on)
    );

    always_comb begin
        rd_data            = '0;
        rd_data[SPARE_BIT] = 1'b1;
        rd_data[MAIN_BIT]  = main_on;
        for (int i = 0; i < NUM_CH; i++) begin
            rd_data[EN_BASE+i]   = en[i];
            rd_data[QUAL_BASE+i] = 1'b1;
            rd_data[IE_BASE+i]   = ie[i];
        end
        chan_active = en & {NUM_CH{main_on}};
        irq_req     = ~en & ie;
    end

    // R12
    nmi_beats_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_evt && wr_en && !wr_data[QUAL_BASE] && wr_data[EN_BASE])
            |=> (chan_active == '0));

    // R7
    nmi_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_evt && !wr_en && term_pulse == '0)
            |=> $stable(rd_data[EN_BASE+NUM_CH-1:EN_BASE]));
endmodule

// File: tb/sim_dma_ctl_reg.sv
module sim_dma_ctl_reg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] term_pulse = '0;
    logic       nmi_evt = 1'b0;
    logic [1:0] chan_active, irq_req;

    int vectors = 0;
    int fails = 0;
    logic [1:0] m_en, m_ie;
    logic       m_main;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_ctl_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .term_pulse(term_pulse), .nmi_evt(nmi_evt),
        .chan_active(chan_active), .irq_req(irq_req)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string en_tag, input string main_tag);
        logic [7:0] exp_rd;
        exp_rd = {m_en[1], m_en[0], 2'b11, m_ie[1], m_ie[0], 1'b1, m_main};
        chk("R4 readback", rd_data, exp_rd);
        chk(en_tag, {6'b0, rd_data[7:6]}, {6'b0, m_en[1], m_en[0]});
        chk(main_tag, {7'b0, rd_data[0]}, {7'b0, m_main});
        chk("R11 ie", {6'b0, rd_data[3:2]}, {6'b0, m_ie});
        chk("R8 active", {6'b0, chan_active}, {6'b0, m_en & {2{m_main}}});
        chk("R10 irq", {6'b0, irq_req}, {6'b0, ~m_en & m_ie});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset rd", rd_data, 8'h32);
        chk("R1 reset active", {6'b0, chan_active}, 8'h00);
        chk("R1 reset irq", {6'b0, irq_req}, 8'h00);
        m_en = 2'b00; m_ie = 2'b00; m_main = 1'b0;

        for (int w = 0; w < 2; w++) begin
            for (int n = 0; n < 2; n++) begin
                for (int t = 0; t < 4; t++) begin
                    for (int d = 0; d < 256; d++) begin
                        logic [7:0] dd;
                        logic [1:0] qwr, setc, nx_en;
                        logic       nx_main;
                        string      en_tag, main_tag;
                        dd = 8'(d);
                        wr_en = w[0]; nmi_evt = n[0]; term_pulse = 2'(t); wr_data = dd;
                        for (int c = 0; c < 2; c++) begin
                            qwr[c]   = wr_en && !dd[4+c];
                            setc[c]  = qwr[c] && dd[6+c];
                            nx_en[c] = term_pulse[c] ? 1'b0 : (qwr[c] ? dd[6+c] : m_en[c]);
                        end
                        nx_main = nmi_evt ? 1'b0 : ((|setc) ? 1'b1 : m_main);
                        if (term_pulse != 0)     en_tag = "R9 term clear";
                        else if (|qwr)           en_tag = "R2 qualified en";
                        else                     en_tag = "R3 en hold";
                        if (nmi_evt && (|setc))  main_tag = "R12 nmi beats set";
                        else if (nmi_evt)        main_tag = "R7 nmi clear";
                        else if (|setc)          main_tag = "R6 main set";
                        else                     main_tag = "R5 main not writable";
                        m_en = nx_en;
                        m_main = nx_main;
                        if (wr_en) m_ie = dd[3:2];
                        @(negedge clk);
                        check_all(en_tag, main_tag);
                    end
                end
            end
        end
        wr_en = 1'b0; nmi_evt = 1'b0; term_pulse = '0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule